// File: doc/BRIEF.md
# Destructive-Readout Core Memory Sequencer

This block runs the access cycles of an 18-bit, 4K-word magnetic-core store. The store is split into two equal halves. One half can be read and written. In the other half, each bit is fixed by how the select wire is threaded, so that half behaves as read-only. Reading a core word destroys it: the read drive pushes every selected bit to ONE, and only the bits that held ZERO produce a sense pulse. The sequencer therefore follows every read with a restore write. That write drives the selected bits toward ZERO and raises inhibit on each bit that must stay ONE.

A processor issues a request while `ready` is high. The request carries a direction, a 12-bit address and, for writes, a data word. The sequencer latches the request and turns the address into one-hot X and Y select strobes plus a region flag. It then steps through the drive, sense and rewrite phases. A write begins with a clearing read whose sensed data is thrown away. In the fixed half the inhibit lines are never driven, so a write or a restore there leaves the stored pattern exactly as it was. Every address bit is still decoded in that half, so the X and Y strobes and the region flag follow the request's address.

Top module: `core_mem_ctrl`

## Requirements
- R1: During and directly after reset, `ready` is 1, and `rd_valid`, `drive_read`, `drive_write`, `inhibit`, `x_sel` and `y_sel` are all 0.
- R2: Address bit 11 of the latched request drives `plane_rom`: 0 means the read/write half and 1 means the fixed half. While either drive is active, `x_sel` is one-hot at index addr[10:5] and `y_sel` is one-hot at index addr[4:0]. Both strobe buses are 0 when no drive is active.
- R3: A read accepted at a clock edge runs `drive_read` for RD_CYC cycles (default 3). One sense cycle with no drive follows. Then `drive_write` runs for WR_CYC cycles (default 3). With the defaults, `ready` is low for 7 cycles. `rd_valid` pulses for one cycle together with the return of `ready`.
- R4: `rd_data` is the bitwise inverse of `sense_in` as sampled during the sense cycle, so a pulse reads as 0 and no pulse reads as 1.
- R5: In the read/write half, `inhibit` during the restore phase equals the word just read, so reading the same address again returns the same word.
- R6: A write runs `drive_read` (clearing read, data discarded) for RD_CYC cycles, then `drive_write` for WR_CYC cycles with `inhibit` equal to the write data. With the defaults, `ready` is low for 6 cycles, and `rd_valid` stays 0.
- R7: `inhibit` is all zero for every cycle of an access to the fixed half. Writing any data there leaves the stored word unchanged.
- R8: `drive_read` and `drive_write` are never high together, and `inhibit` is nonzero only while `drive_write` is high.
- R9: A request presented while `ready` is low has no effect. The cycle in progress keeps its address and timing, and the memory contents do not change.
- R10: A request held high is accepted at the edge where `ready` has returned. A read can therefore start in the same cycle in which the previous read's `rd_valid` is shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, taken when `ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Bit 11 region, bits 10:5 X line, bits 4:0 Y line |
| req_wdata | input | 18 | Write data |
| ready | output | 1 | Sequencer idle and able to accept a request |
| rd_valid | output | 1 | One-cycle strobe: `rd_data` holds a completed read |
| rd_data | output | 18 | Read result |
| x_sel | output | 64 | One-hot X select strobe |
| y_sel | output | 32 | One-hot Y select strobe |
| plane_rom | output | 1 | Latched region flag, 1 = fixed half |
| drive_read | output | 1 | Read-polarity drive (switches selected bits to ONE) |
| drive_write | output | 1 | Write-polarity drive (switches selected bits to ZERO) |
| sense_in | input | 18 | Sense pulses, one per bit |
| inhibit | output | 18 | Per-bit inhibit, keeps a bit at ONE during a write drive |

## Verification
Two events can fall in the same cycle. One is the end of a read, when `rd_valid` is shown with its result. The other is the acceptance of the next request, whose address is latched at that same edge. The bench provokes this by holding `req_valid` high across a whole read. It then checks that `ready` is high with `rd_valid` for exactly one cycle and falls at the next edge. The scoreboard must then receive two identical results, in order. In a second case, a conflicting write is pulsed in the middle of a busy read. The bench judges that the read's duration and result do not change and that the word at the address is intact afterwards.

// File: rtl/core_mem_pkg.sv
package core_mem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_READ_DRIVE  = 3'd1,
        ST_SENSE       = 3'd2,
        ST_RESTORE     = 3'd3,
        ST_CLEAR_READ  = 3'd4,
        ST_WRITE_DRIVE = 3'd5
    } cyc_state_e;

endpackage

// File: rtl/core_addr_decode.sv
module core_addr_decode #(
    parameter int X_W = 6,
    parameter int Y_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [X_W+Y_W:0]     addr,
    input  logic                 en,
    output logic [(1<<X_W)-1:0]  x_sel,
    output logic [(1<<Y_W)-1:0]  y_sel,
    output logic                 rom
);
    localparam int X_LINES = 1 << X_W;
    localparam int Y_LINES = 1 << Y_W;

    logic [X_W-1:0] x_idx;
    logic [Y_W-1:0] y_idx;

    assign x_idx = addr[Y_W +: X_W];
    assign y_idx = addr[Y_W-1:0];
    assign rom   = addr[X_W+Y_W];

    for (genvar gx = 0; gx < X_LINES; gx++) begin : g_x
        assign x_sel[gx] = en && (x_idx == X_W'(gx));
    end

    for (genvar gy = 0; gy < Y_LINES; gy++) begin : g_y
        assign y_sel[gy] = en && (y_idx == Y_W'(gy));
    end

    AST_X_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ($onehot(x_sel) && $onehot(y_sel))); // R2

    AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> ($countones(x_sel) == 0 && $countones(y_sel) == 0)); // R2

endmodule

// File: rtl/core_cycle_fsm.sv
module core_cycle_fsm
    import core_mem_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int RD_CYC = 3,
    parameter int WR_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              ready,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] addr_q,
    output logic              load_wdata,
    output logic              capture,
    output logic              drive_rd,
    output logic              drive_wr
);
    localparam int CNT_MAX = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        cyc_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              rdv;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.rdv    = 1'b0;
        load_wdata = 1'b0;
        capture    = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.addr   = req_addr;
                    s_d.cnt    = CNT_W'(RD_CYC - 1);
                    s_d.st     = req_write ? ST_CLEAR_READ : ST_READ_DRIVE;
                    load_wdata = req_write;
                end
            end
            ST_READ_DRIVE: begin
                if (s_q.cnt == '0) s_d.st = ST_SENSE;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            ST_SENSE: begin
                capture = 1'b1;
                s_d.st  = ST_RESTORE;
                s_d.cnt = CNT_W'(WR_CYC - 1);
            end
            ST_RESTORE: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = ST_IDLE;
                    s_d.rdv = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_CLEAR_READ: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = ST_WRITE_DRIVE;
                    s_d.cnt = CNT_W'(WR_CYC - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_WRITE_DRIVE: begin
                if (s_q.cnt == '0) s_d.st = ST_IDLE;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.cnt  <= '0;
            s_q.addr <= '0;
            s_q.rdv  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready    = (s_q.st == ST_IDLE);
    assign rd_valid = s_q.rdv;
    assign addr_q   = s_q.addr;
    assign drive_rd = (s_q.st == ST_READ_DRIVE) || (s_q.st == ST_CLEAR_READ);
    assign drive_wr = (s_q.st == ST_RESTORE) || (s_q.st == ST_WRITE_DRIVE);

    AST_RDV_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ready); // R3

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready); // R9

    AST_BUSY_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> $stable(addr_q)); // R9

    AST_READY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!drive_rd && !drive_wr)); // R1

endmodule

// File: rtl/core_bit_lane.sv
module core_bit_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic wbit,
    input  logic capture,
    input  logic sense,
    input  logic drive_wr,
    input  logic rom,
    output logic data,
    output logic inhibit
);
    logic data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (load)         data_d = wbit;
        else if (capture) data_d = ~sense;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= 1'b0;
        else        data_q <= data_d;
    end

    assign data    = data_q;
    assign inhibit = drive_wr && !rom && data_q;

    AST_INH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> drive_wr); // R8

    AST_ROM_NO_INH: assert property (@(posedge clk) disable iff (!rst_n)
        rom |-> !inhibit); // R7

endmodule

// File: rtl/core_mem_ctrl.sv
module core_mem_ctrl #(
    parameter int WORD_W = 18,
    parameter int X_W    = 6,
    parameter int Y_W    = 5,
    parameter int RD_CYC = 3,
    parameter int WR_CYC = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [X_W+Y_W:0]      req_addr,
    input  logic [WORD_W-1:0]     req_wdata,
    output logic                  ready,
    output logic                  rd_valid,
    output logic [WORD_W-1:0]     rd_data,
    output logic [(1<<X_W)-1:0]   x_sel,
    output logic [(1<<Y_W)-1:0]   y_sel,
    output logic                  plane_rom,
    output logic                  drive_read,
    output logic                  drive_write,
    input  logic [WORD_W-1:0]     sense_in,
    output logic [WORD_W-1:0]     inhibit
);
    localparam int ADDR_W = X_W + Y_W + 1;

    logic [ADDR_W-1:0] addr_q;
    logic              load_wdata;
    logic              capture;

    core_cycle_fsm #(
        .ADDR_W (ADDR_W),
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .ready      (ready),
        .rd_valid   (rd_valid),
        .addr_q     (addr_q),
        .load_wdata (load_wdata),
        .capture    (capture),
        .drive_rd   (drive_read),
        .drive_wr   (drive_write)
    );

    core_addr_decode #(
        .X_W (X_W),
        .Y_W (Y_W)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr_q),
        .en    (drive_read || drive_write),
        .x_sel (x_sel),
        .y_sel (y_sel),
        .rom   (plane_rom)
    );

    for (genvar gb = 0; gb < WORD_W; gb++) begin : g_lane
        core_bit_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_wdata),
            .wbit     (req_wdata[gb]),
            .capture  (capture),
            .sense    (sense_in[gb]),
            .drive_wr (drive_write),
            .rom      (plane_rom),
            .data     (rd_data[gb]),
            .inhibit  (inhibit[gb])
        );
    end

    AST_DRIVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_read && drive_write)); // R8

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(drive_read) && !drive_write) |=> drive_write); // R3

endmodule

// File: tb/tb_core_mem_ctrl.sv
package tb_core_pkg;
    function automatic logic [17:0] rom_pattern(logic [10:0] a);
        return {a, ~a[6:0]} ^ 18'h2A5C3;
    endfunction
endpackage

module core_plane_emu #(
    parameter int X_W    = 6,
    parameter int Y_W    = 5,
    parameter int WORD_W = 18,
    parameter int ROWS   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [(1<<X_W)-1:0]  x_sel,
    input  logic [(1<<Y_W)-1:0]  y_sel,
    input  logic                 plane_rom,
    input  logic                 drive_read,
    input  logic                 drive_write,
    input  logic [WORD_W-1:0]    inhibit,
    output logic [WORD_W-1:0]    sense
);
    localparam int WORDS = ROWS << Y_W;
    logic [WORD_W-1:0] mem [WORDS];
    logic rd_p, wr_p;
    int xi, yi, idx;
    logic [10:0] ra;

    always_comb begin
        xi = -1;
        yi = -1;
        for (int i = 0; i < (1 << X_W); i++) if (x_sel[i]) xi = i;
        for (int i = 0; i < (1 << Y_W); i++) if (y_sel[i]) yi = i;
        idx = xi * (1 << Y_W) + yi;
        ra  = {xi[5:0], yi[4:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
            sense <= '0;
            rd_p  <= 1'b0;
            wr_p  <= 1'b0;
        end else begin
            rd_p <= drive_read;
            wr_p <= drive_write;
            if (drive_read && !rd_p && xi >= 0 && yi >= 0) begin
                if (plane_rom) begin
                    sense <= ~tb_core_pkg::rom_pattern(ra);
                end else if (xi < ROWS) begin
                    sense    <= ~mem[idx];
                    mem[idx] <= '1;
                end
            end
            if (drive_write && !wr_p && !plane_rom && xi >= 0 && xi < ROWS && yi >= 0)
                mem[idx] <= inhibit;
        end
    end
endmodule

module tb_core_mem_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [17:0] req_wdata = '0;
    logic        ready, rd_valid, plane_rom, drive_read, drive_write;
    logic [17:0] rd_data, sense_in, inhibit;
    logic [63:0] x_sel;
    logic [31:0] y_sel;

    int checks = 0;
    int fails  = 0;
    int bad_rom_inh = 0;
    int bad_inh_drv = 0;

    logic [17:0] exp_q[$];
    logic [17:0] shadow[int];

    always #(CLK_PERIOD/2) clk = ~clk;

    core_mem_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .x_sel(x_sel), .y_sel(y_sel), .plane_rom(plane_rom),
        .drive_read(drive_read), .drive_write(drive_write), .sense_in(sense_in),
        .inhibit(inhibit)
    );

    core_plane_emu u_emu (
        .clk(clk), .rst_n(rst_n), .x_sel(x_sel), .y_sel(y_sel), .plane_rom(plane_rom),
        .drive_read(drive_read), .drive_write(drive_write), .inhibit(inhibit),
        .sense(sense_in)
    );

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] expect_word(logic [11:0] a);
        if (a[11]) return tb_core_pkg::rom_pattern(a[10:0]);
        if (shadow.exists(int'(a))) return shadow[int'(a)];
        return '0;
    endfunction

    // scoreboard monitor: R4 R5 R7 results
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected rd_valid", 64'(rd_data), 64'd0);
            end else begin
                logic [17:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R4 read data", 64'(rd_data), 64'(e));
            end
        end
        if (rst_n && plane_rom && inhibit != 0) bad_rom_inh++;
        if (rst_n && inhibit != 0 && !drive_write) bad_inh_drv++;
        if (rst_n && drive_read && drive_write) bad_inh_drv++;
    end

    task automatic access(bit wr, logic [11:0] a, logic [17:0] wd, bit poke, string tag);
        int busy;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        if (!wr) exp_q.push_back(expect_word(a));
        else if (!a[11]) shadow[int'(a)] = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(drive_read && x_sel == (64'd1 << a[10:5]) && y_sel == (32'd1 << a[4:0])
            && plane_rom == a[11], {"R2 select ", tag}, {x_sel[31:0], y_sel}, 64'(a));
        busy = 0;
        while (!ready) begin
            busy++;
            if (poke && busy == 2) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = 18'h0;
            end
            if (poke && busy == 4) req_valid = 1'b0;
            @(negedge clk);
        end
        chk(busy == (wr ? 6 : 7), wr ? "R6 write length" : "R3 read length",
            64'(busy), wr ? 64'd6 : 64'd7);
        if (wr) chk(!rd_valid, "R6 no rd_valid on write", 64'(rd_valid), 64'd0);
        else    chk(rd_valid, "R3 rd_valid with ready", 64'(rd_valid), 64'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ready && !rd_valid && !drive_read && !drive_write && inhibit == 0
            && x_sel == 0 && y_sel == 0, "R1 reset state",
            {ready, rd_valid, drive_read, drive_write}, 64'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && !drive_read && !drive_write, "R1 after reset", 64'(ready), 64'd1);

        access(0, 12'h021, '0, 0, "fresh read");              // R4
        access(1, 12'h021, 18'h2B3C5, 0, "write");             // R6
        access(0, 12'h021, '0, 0, "read back");                // R5
        access(0, 12'h021, '0, 0, "reread after restore");     // R5
        access(1, 12'h05F, 18'h3FFFF, 0, "write ones");
        access(0, 12'h05F, '0, 0, "read ones");
        access(1, 12'h000, 18'h00000, 0, "write zeros");
        access(0, 12'h000, '0, 0, "read zeros");
        access(1, 12'h07F, 18'h15555, 0, "write alt");
        access(0, 12'h07F, '0, 0, "read alt");
        access(0, 12'h07F, '0, 0, "reread alt");               // R5

        access(0, 12'h800, '0, 0, "rom low");                   // R7
        access(0, 12'hABC, '0, 0, "rom mid");
        access(0, 12'hFFF, '0, 0, "rom top");
        access(1, 12'hABC, ~tb_core_pkg::rom_pattern(11'h2BC), 0, "rom write inverse"); // R7
        access(0, 12'hABC, '0, 0, "rom after write");
        access(1, 12'h800, 18'h00000, 0, "rom write zero");
        access(0, 12'h800, '0, 0, "rom after zero write");
        access(0, 12'h800, '0, 0, "rom reread");

        // R9: write pulsed into a busy read must not land
        access(0, 12'h021, '0, 1, "busy poke");
        access(0, 12'h021, '0, 0, "after poke");

        // R10: request held across a read is taken again when ready returns
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h05F;
        exp_q.push_back(expect_word(12'h05F));
        exp_q.push_back(expect_word(12'h05F));
        repeat (8) @(negedge clk);
        chk(ready && rd_valid, "R10 ready with rd_valid", {ready, rd_valid}, 64'h3);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!ready && drive_read, "R10 next read started", {ready, drive_read}, 64'h1);
        while (!ready) @(negedge clk);
        repeat (3) @(negedge clk);

        chk(exp_q.size() == 0, "R3 all reads returned", 64'(exp_q.size()), 64'd0);
        chk(bad_rom_inh == 0, "R7 no inhibit in fixed half", 64'(bad_rom_inh), 64'd0);
        chk(bad_inh_drv == 0, "R8 drive and inhibit rules", 64'(bad_inh_drv), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule